// File: doc/BRIEF.md
# Camera Cartridge Bank Controller

This block is the bank controller of a cartridge for an 8-bit handheld console bus. The cartridge also carries a peripheral whose registers sit in the external RAM window. The controller watches CPU writes to the low half of the address space (0x0000–0x7FFF) and keeps three pieces of control state: a RAM enable, a six-bit ROM bank for the switchable upper ROM window, and a four-bit RAM bank together with a peripheral-register flag. From that state it forms the addresses for the external ROM and RAM arrays and the write enable for the RAM. It also picks the byte returned on reads of the 8 KiB external RAM window at 0xA000–0xBFFF.

The console selects this controller when the cartridge type byte is 0xFC. The memory arrays and the peripheral's own registers lie outside the block. The RAM read byte comes in on `ram_rdata_i`, and the controller passes it through, masks it with 0xFF, or forces 0x00.

Top module: `cam_mbc`

## Requirements
- R1: After reset, RAM is disabled (window reads return 0xFF), register mode is clear, the RAM bank is 0 and the upper ROM window maps to bank 1.
- R2: A write with address bits [15:13] equal to 0, 1 or 2 updates the RAM enable, ROM bank or RAM bank/mode control respectively. A write with [15:13] equal to 3, or any write at 0x8000 or above, leaves all control state unchanged.
- R3: Writing 0x0A to the enable region turns RAM on and writing 0x00 turns it off. Any other value leaves the enable as it was.
- R4: The ROM bank takes bits [5:0] of the written byte. `rom_addr_o` is {bank, addr[13:0]} when addr[14] is 1 and {6'b0, addr[13:0]} when it is 0. A written bank of 0 maps the upper window to bank 0.
- R5: Writing a value below 0x10 to the bank/mode region loads the RAM bank with that value and clears register mode. `ram_addr_o` is {ram_bank, addr[12:0]}.
- R6: Writing 0x10 or more to the bank/mode region sets register mode and keeps the RAM bank unchanged.
- R7: While register mode is set, every read of the RAM window returns 0x00, whether RAM is on or off.
- R8: Outside register mode with RAM off, window reads return 0xFF.
- R9: Outside register mode with RAM on, window reads return `ram_rdata_i`.
- R10: `ram_we_o` is high only during a write to 0xA000–0xBFFF while RAM is on and register mode is clear.
- R11: A control write takes effect at the clock edge that samples it, so the outputs reflect it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| ram_rdata_i | input | 8 | Byte read from the external RAM array |
| rd_data_o | output | 8 | Byte returned for a RAM-window read (defined for 0xA000–0xBFFF) |
| rom_addr_o | output | 20 | Physical ROM address |
| ram_addr_o | output | 17 | Physical RAM address |
| ram_we_o | output | 1 | Write enable to the RAM array |

## Verification
The assertions assume that `wr_i`, `addr_i` and `wdata_i` are stable across the sampling edge and that each write strobe lasts a single cycle. The stimulus changes inputs only on falling edges and keeps the strobe high for one cycle. Read-path checks are made only for addresses inside the RAM window, so an undefined `rd_data_o` elsewhere is never compared. The bench drives `ram_rdata_i` from a fixed function of the address, which lets the expected pass-through byte be worked out without an array model.

// File: rtl/cam_mbc_pkg.sv
package cam_mbc_pkg;
  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_RAMB = 2'd2,
    SEL_NONE = 2'd3
  } ctrl_sel_e;

  localparam logic [7:0] EN_KEY  = 8'h0A;
  localparam logic [7:0] DIS_KEY = 8'h00;
  localparam logic [2:0] RAM_WIN = 3'b101;
  localparam logic [7:0] REG_RD  = 8'h00;
  localparam logic [7:0] OFF_RD  = 8'hFF;
endpackage

// File: rtl/cam_mbc_decode.sv
module cam_mbc_decode
  import cam_mbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic              ctrl_wr_o,
  output ctrl_sel_e         sel_o,
  output logic              win_hit_o
);
  localparam int TOP = ADDR_W - 1;

  assign ctrl_wr_o = wr_i & ~addr_i[TOP];
  assign sel_o     = ctrl_sel_e'(addr_i[TOP-1:TOP-2]);
  assign win_hit_o = (addr_i[TOP:TOP-2] == RAM_WIN);
endmodule

// File: rtl/cam_mbc_regs.sv
module cam_mbc_regs
  import cam_mbc_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int ROM_BANK_W     = 6,
  parameter int RAM_BANK_W     = 4,
  parameter int ROM_RESET_BANK = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctrl_wr_i,
  input  ctrl_sel_e             sel_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  ram_en_o,
  output logic                  reg_mode_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o
);
  localparam logic [DATA_W-1:0] MODE_THR = DATA_W'(1 << RAM_BANK_W);

  logic wr_en, wr_rom, wr_ramb, is_reg;

  assign wr_en   = ctrl_wr_i && (sel_i == SEL_EN);
  assign wr_rom  = ctrl_wr_i && (sel_i == SEL_ROM);
  assign wr_ramb = ctrl_wr_i && (sel_i == SEL_RAMB);
  assign is_reg  = (wdata_i >= MODE_THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_en_o <= 1'b0;
    end else if (wr_en) begin
      if (wdata_i == EN_KEY)       ram_en_o <= 1'b1;
      else if (wdata_i == DIS_KEY) ram_en_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rom_bank_o <= ROM_BANK_W'(ROM_RESET_BANK);
    else if (wr_rom) rom_bank_o <= wdata_i[ROM_BANK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_mode_o <= 1'b0;
      ram_bank_o <= '0;
    end else if (wr_ramb) begin
      reg_mode_o <= is_reg;
      if (!is_reg) ram_bank_o <= wdata_i[RAM_BANK_W-1:0];
    end
  end
endmodule

// File: rtl/cam_mbc_rom_map.sv
module cam_mbc_rom_map #(
  parameter int ADDR_W     = 16,
  parameter int ROM_BANK_W = 6
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ROM_BANK_W-1:0]   rom_bank_i,
  output logic [ROM_BANK_W+13:0]  rom_addr_o
);
  logic [ROM_BANK_W-1:0] eff_bank;

  // bit 14 splits the fixed lower window from the switched upper one
  assign eff_bank   = addr_i[14] ? rom_bank_i : '0;
  assign rom_addr_o = {eff_bank, addr_i[13:0]};
endmodule

// File: rtl/cam_mbc_ram_port.sv
module cam_mbc_ram_port
  import cam_mbc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAM_BANK_W = 4
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic                    win_hit_i,
  input  logic                    ram_en_i,
  input  logic                    reg_mode_i,
  input  logic [RAM_BANK_W-1:0]   ram_bank_i,
  input  logic [DATA_W-1:0]       ram_rdata_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [RAM_BANK_W+12:0]  ram_addr_o,
  output logic                    ram_we_o
);
  assign ram_addr_o = {ram_bank_i, addr_i[12:0]};
  assign ram_we_o   = wr_i & win_hit_i & ram_en_i & ~reg_mode_i;

  // register mode wins over the enable
  always_comb begin
    if (reg_mode_i)     rd_data_o = REG_RD;
    else if (!ram_en_i) rd_data_o = OFF_RD;
    else                rd_data_o = ram_rdata_i;
  end
endmodule

// File: rtl/cam_mbc.sv
module cam_mbc
  import cam_mbc_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int ROM_BANK_W     = 6,
  parameter int RAM_BANK_W     = 4,
  parameter int ROM_RESET_BANK = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   wr_i,
  input  logic [DATA_W-1:0]      ram_rdata_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [ROM_BANK_W+13:0] rom_addr_o,
  output logic [RAM_BANK_W+12:0] ram_addr_o,
  output logic                   ram_we_o
);
  logic                  ctrl_wr, win_hit;
  ctrl_sel_e             sel;
  logic                  ram_en, reg_mode;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic [ROM_BANK_W-1:0] rom_bank;

  cam_mbc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i),
    .ctrl_wr_o(ctrl_wr), .sel_o(sel), .win_hit_o(win_hit)
  );

  cam_mbc_regs #(
    .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W), .ROM_RESET_BANK(ROM_RESET_BANK)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr), .sel_i(sel),
    .wdata_i(wdata_i), .ram_en_o(ram_en), .reg_mode_o(reg_mode),
    .ram_bank_o(ram_bank), .rom_bank_o(rom_bank)
  );

  cam_mbc_rom_map #(.ADDR_W(ADDR_W), .ROM_BANK_W(ROM_BANK_W)) u_rom (
    .addr_i(addr_i), .rom_bank_i(rom_bank), .rom_addr_o(rom_addr_o)
  );

  cam_mbc_ram_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BANK_W(RAM_BANK_W)
  ) u_ram (
    .addr_i(addr_i), .wr_i(wr_i), .win_hit_i(win_hit), .ram_en_i(ram_en),
    .reg_mode_i(reg_mode), .ram_bank_i(ram_bank), .ram_rdata_i(ram_rdata_i),
    .rd_data_o(rd_data_o), .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o)
  );
endmodule

// File: rtl/cam_mbc_checker.sv
module cam_mbc_checker #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 6,
  parameter int RAM_BANK_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [DATA_W-1:0]      wdata_i,
  input logic                   wr_i,
  input logic [DATA_W-1:0]      rd_data_o,
  input logic [ROM_BANK_W+13:0] rom_addr_o,
  input logic                   ram_we_o,
  input logic                   ram_en,
  input logic                   reg_mode,
  input logic [RAM_BANK_W-1:0]  ram_bank,
  input logic [ROM_BANK_W-1:0]  rom_bank
);
  logic in_win, w0, w1, w2;
  assign in_win = (addr_i[ADDR_W-1:ADDR_W-3] == 3'b101);
  assign w0 = wr_i && (addr_i[ADDR_W-1:ADDR_W-3] == 3'd0);
  assign w1 = wr_i && (addr_i[ADDR_W-1:ADDR_W-3] == 3'd1);
  assign w2 = wr_i && (addr_i[ADDR_W-1:ADDR_W-3] == 3'd2);

  p_en_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w0 && wdata_i == 8'h0A |=> ram_en);
  p_en_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w0 && wdata_i != 8'h0A && wdata_i != 8'h00 |=> $stable(ram_en));
  p_rom_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1 |=> rom_bank == $past(wdata_i[ROM_BANK_W-1:0]));
  p_rom_lower_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[14] |-> rom_addr_o[ROM_BANK_W+13:14] == '0);
  p_bank_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w2 && wdata_i < 8'h10 |=> !reg_mode && ram_bank == $past(wdata_i[RAM_BANK_W-1:0]));
  p_reg_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w2 && wdata_i >= 8'h10 |=> reg_mode && $stable(ram_bank));
  p_reg_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win && reg_mode |-> rd_data_o == 8'h00);
  p_off_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win && !reg_mode && !ram_en |-> rd_data_o == 8'hFF);
  p_we_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> wr_i && in_win && ram_en && !reg_mode);
  p_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i[ADDR_W-1] || addr_i[ADDR_W-2:ADDR_W-3] == 2'd3)
    |=> $stable(ram_en) && $stable(reg_mode) && $stable(ram_bank) && $stable(rom_bank));
endmodule

bind cam_mbc cam_mbc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i),
  .rd_data_o(rd_data_o), .rom_addr_o(rom_addr_o), .ram_we_o(ram_we_o),
  .ram_en(ram_en), .reg_mode(reg_mode), .ram_bank(ram_bank), .rom_bank(rom_bank)
);

// File: tb/cam_mbc_bench.sv
`timescale 1ns/1ps
module cam_mbc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  ram_rdata_i;
  logic [7:0]  rd_data_o;
  logic [19:0] rom_addr_o;
  logic [16:0] ram_addr_o;
  logic        ram_we_o;

  always #2 clk_i = ~clk_i;

  assign ram_rdata_i = addr_i[7:0] ^ 8'h5A;

  cam_mbc u_cam_mbc (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .ram_rdata_i(ram_rdata_i), .rd_data_o(rd_data_o),
    .rom_addr_o(rom_addr_o), .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o)
  );

  typedef enum int {K_RD, K_ROM, K_RAMA, K_WE} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor: compare queued expectations shortly after each rising edge
  initial forever begin
    @(posedge clk_i);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = 32'(rd_data_o);
        K_ROM:   act = 32'(rom_addr_o);
        K_RAMA:  act = 32'(ram_addr_o);
        default: act = 32'(ram_we_o);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic chk(input kind_e k, input logic [15:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
    @(posedge clk_i);
    #2;
  endtask

  // write into the RAM window and check the strobe during that cycle
  task automatic chk_we(input logic [15:0] a, input logic e, input string r);
    item_t it;
    @(negedge clk_i);
    addr_i = a; wdata_i = 8'h77; wr_i = 1'b1;
    it.kind = K_WE; it.exp = 32'(e); it.req = r;
    q.push_back(it);
    @(posedge clk_i);
    #2;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(K_RD,   16'hA000, 32'hFF,    "R1");
    chk(K_ROM,  16'h4000, 32'h04000, "R1");
    chk(K_RAMA, 16'hA123, 32'h00123, "R1");
    // R4 ROM bank
    wr(16'h2000, 8'hC5);
    chk(K_ROM, 16'h7FFF, 32'h17FFF, "R4");
    chk(K_ROM, 16'h1234, 32'h01234, "R4");
    wr(16'h3FFF, 8'h3F);
    chk(K_ROM, 16'h4001, 32'hFC001, "R4");
    wr(16'h2000, 8'h00);
    chk(K_ROM, 16'h4000, 32'h00000, "R4");
    // R3 / R9 / R11 enable
    wr(16'h0000, 8'h0A);
    chk(K_RD, 16'hA010, 32'h4A, "R9");
    wr(16'h1FFF, 8'h05);
    chk(K_RD, 16'hA011, 32'h4B, "R3");
    wr(16'h0000, 8'h00);
    chk(K_RD, 16'hA011, 32'hFF, "R8");
    wr(16'h0100, 8'h0B);
    chk(K_RD, 16'hA011, 32'hFF, "R3");
    // R2 ignored regions
    wr(16'h6000, 8'h0A);
    chk(K_RD, 16'hA000, 32'hFF, "R2");
    wr(16'hC000, 8'h0A);
    chk(K_RD, 16'hA000, 32'hFF, "R2");
    wr(16'hA000, 8'h0A);
    chk(K_RD, 16'hA000, 32'hFF, "R2");
    wr(16'h6000, 8'h03);
    chk(K_RAMA, 16'hA000, 32'h00000, "R2");
    // R5 RAM bank
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h07);
    chk(K_RAMA, 16'hB456, 32'h0F456, "R5");
    chk(K_RD,   16'hB456, 32'h0C,    "R9");
    // R6 / R7 register mode
    wr(16'h5000, 8'h10);
    chk(K_RAMA, 16'hB456, 32'h0F456, "R6");
    chk(K_RD,   16'hB456, 32'h00,    "R7");
    wr(16'h0000, 8'h00);
    chk(K_RD,   16'hB456, 32'h00,    "R7");
    wr(16'h4000, 8'hFF);
    chk(K_RAMA, 16'hA000, 32'h0E000, "R6");
    wr(16'h4000, 8'h0F);
    chk(K_RD,   16'hA000, 32'hFF,    "R5");
    chk(K_RAMA, 16'hA000, 32'h1E000, "R5");
    // R10 write strobe
    wr(16'h0000, 8'h0A);
    chk_we(16'hA005, 1'b1, "R10");
    wr(16'h4000, 8'h20);
    chk_we(16'hA005, 1'b0, "R10");
    wr(16'h4000, 8'h02);
    wr(16'h0000, 8'h00);
    chk_we(16'hBFFF, 1'b0, "R10");
    wr(16'h0000, 8'h0A);
    chk_we(16'hC000, 1'b0, "R10");
    chk_we(16'h9FFF, 1'b0, "R10");
    chk_we(16'hBFFF, 1'b1, "R10");
    // R11: enable visible on the cycle after its write edge
    wr(16'h0000, 8'h00);
    chk(K_RD, 16'hA0AA, 32'hFF, "R11");
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule